// File: doc/BRIEF.md
# Sampling Event Counter with Overflow Interrupt

This block counts qualifying events for sampled performance monitoring. It holds a 40-bit count that software reads back at full width. The count advances by one in each clock cycle where the event input is high and the counting enable is set. The enable is a register that software sets or clears through its own strobe.

Software sets a sampling period by writing a 32-bit value. The block fills the upper eight bits with copies of bit 31 of that value. Writing the two's-complement negative of N therefore makes the 40-bit count reach all ones after N-1 events and wrap to zero on the N-th. A single write can program at most 2^31 events. The wrap sets a sticky interrupt flag, which stays high until a clear strobe arrives.

In narrow mode the interrupt output does not show the sticky flag. It follows bit 31 of the count directly as a level request. The write port follows valid/ready. `wr_ready` is always high, so a write is taken in every cycle where `wr_valid` is high and the port never applies back-pressure. Enable, clear and mode are plain control pins.

Top module: `evt_sample_ctr`

## Requirements
- R1: After reset, the count reads zero, `irq` is low and counting is disabled, so event pulses do not change the count until the enable is written high.
- R2: While enabled and not written, the count rises by exactly one in each cycle where `evt` is high and holds when `evt` is low; the new value is visible after that clock edge.
- R3: While the enable register is low, `evt` pulses leave the count unchanged. An enable write (`en_we` with `en_din`) takes effect from the following cycle.
- R4: A write accepted on the port sets count bits 31:0 to `wr_data` and each of bits 39:32 to `wr_data[31]`.
- R5: When a write and a counted event occur in the same cycle, the count becomes the written value and the event is lost.
- R6: `rd_count` presents all 40 bits of the count, including the sign-extended upper bits.
- R7: An increment from all ones gives a count of zero and sets the sticky flag. In wide mode (`narrow_mode` low) the flag drives `irq` from the cycle after the wrap.
- R8: The flag stays set through later events until `irq_clr` is high. A clear in the same cycle as a wrap leaves the flag set.
- R9: With `narrow_mode` high, `irq` equals bit 31 of the count. It is high while that bit is 1 and low while it is 0.
- R10: Writing the 32-bit negative of N (1 <= N <= 2^31) makes the flag set on exactly the N-th counted event and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 1: irq follows count bit 31; 0: irq shows sticky flag |
| en_we | input | 1 | Enable register write strobe |
| en_din | input | 1 | Value written to the enable register |
| evt | input | 1 | Qualified event pulse, one count per high cycle |
| wr_valid | input | 1 | Count write request |
| wr_ready | output | 1 | Always high; write accepted whenever valid |
| wr_data | input | 32 | Low 32 bits of the new count, bit 31 sign-extended |
| rd_count | output | 40 | Full-width count |
| irq_clr | input | 1 | Clears the sticky flag |
| irq | output | 1 | Interrupt request |

## Verification
The count path is tested with four kinds of input pattern. Runs of events, with and without gaps, test the plus-one step. Events with the enable low, including the cycle where the enable is written, show that gating has exactly a one-cycle delay. Writes with bit 31 low and with bit 31 high show zero fill against one fill of the upper byte, and a write that coincides with an event shows that the write wins.

Overflow is tested by preloading minus five and checking `irq` after each event, which tells a wrap on the fifth event from one a cycle early or late. A wrap that coincides with a clear tests the set-wins rule. Narrow mode is tested on both sides of bit 31, which tells a level request from the sticky flag.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int unsigned CNT_W_DEF = 40;
  localparam int unsigned WR_W_DEF  = 32;

  // One-cycle command to the count register
  typedef struct packed {
    logic ld;   // load sign-extended write data
    logic inc;  // add one
  } ctr_cmd_t;
endpackage

// File: rtl/evt_ctr_sext.sv
module evt_ctr_sext #(
  parameter int unsigned CNT_W = 40,
  parameter int unsigned WR_W  = 32
) (
  input  logic [WR_W-1:0]  din,
  output logic [CNT_W-1:0] dout
);
  localparam int unsigned EXT_W = CNT_W - WR_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign dout = {{EXT_W{din[WR_W-1]}}, din};
    end else begin : g_same
      assign dout = din[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/evt_ctr_core.sv
module evt_ctr_core
  import evt_ctr_pkg::*;
#(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_cmd_t         cmd_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = &cnt_q;
  assign wrap_o = cmd_i.inc & ~cmd_i.ld & at_max;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cmd_i.ld) begin
      cnt_q <= ld_val_i;
    end else if (cmd_i.inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.ld |=> cnt_q == $past(ld_val_i));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.inc && !cmd_i.ld) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i.inc && !cmd_i.ld) |=> $stable(cnt_q));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/evt_ctr_flag.sv
module evt_ctr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/evt_sample_ctr.sv
module evt_sample_ctr
  import evt_ctr_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned WR_W  = WR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             narrow_mode,
  input  logic             en_we,
  input  logic             en_din,
  input  logic             evt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WR_W-1:0]  wr_data,
  output logic [CNT_W-1:0] rd_count,
  input  logic             irq_clr,
  output logic             irq
);
  localparam int unsigned LVL_BIT = WR_W - 1;

  logic             en_q;
  logic             wr_take;
  logic [CNT_W-1:0] ld_val;
  logic             wrap;
  logic             flag;
  ctr_cmd_t         cmd;

  assign wr_ready = 1'b1;
  assign wr_take  = wr_valid & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_din;
    end
  end

  // Write outranks a counted event in the same cycle
  always_comb begin
    cmd.ld  = wr_take;
    cmd.inc = evt & en_q & ~wr_take;
  end

  evt_ctr_sext #(.CNT_W(CNT_W), .WR_W(WR_W)) u_sext (
    .din  (wr_data),
    .dout (ld_val)
  );

  evt_ctr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .ld_val_i (ld_val),
    .cnt_o    (rd_count),
    .wrap_o   (wrap)
  );

  evt_ctr_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap),
    .clr_i  (irq_clr),
    .flag_o (flag)
  );

  assign irq = narrow_mode ? rd_count[LVL_BIT] : flag;

  // R5
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && evt) |=> rd_count[WR_W-1:0] == $past(wr_data));

  // R3
  gated_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_valid) |=> $stable(rd_count));
endmodule

// File: tb/evt_sample_ctr_bench.sv
module evt_sample_ctr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        en_we = 1'b0;
  logic        en_din = 1'b0;
  logic        evt = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [39:0] rd_count;
  logic        irq_clr = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [39:0] q_cnt[$];
  logic        q_irq[$];
  string       q_tag[$];

  // independent expectation state
  logic [39:0] m_cnt = '0;
  logic        m_flag = 1'b0;
  logic        m_en = 1'b0;

  always #5 clk = ~clk;

  evt_sample_ctr u_evt_sample_ctr (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .en_we(en_we), .en_din(en_din), .evt(evt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_count(rd_count), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic step(input logic e, input logic ewe, input logic edin,
                      input logic wv, input logic [31:0] wd,
                      input logic clr, input logic nm, input string tag);
    logic wrapped;
    @(negedge clk);
    evt = e; en_we = ewe; en_din = edin; wr_valid = wv;
    wr_data = wd; irq_clr = clr; narrow_mode = nm;
    wrapped = 1'b0;
    if (wv) m_cnt = {{8{wd[31]}}, wd};
    else if (e && m_en) begin
      wrapped = (m_cnt == 40'hFF_FFFF_FFFF);
      m_cnt = m_cnt + 40'd1;
    end
    if (wrapped) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (ewe) m_en = edin;
    q_cnt.push_back(m_cnt);
    q_irq.push_back(nm ? m_cnt[31] : m_flag);
    q_tag.push_back(tag);
  endtask

  // monitor: compare 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_cnt.size() > 0) begin
        logic [39:0] ec;
        logic        ei;
        string       et;
        ec = q_cnt.pop_front();
        ei = q_irq.pop_front();
        et = q_tag.pop_front();
        n_cmp++;
        if (rd_count !== ec || irq !== ei) begin
          n_bad++;
          $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                   et, rd_count, irq, ec, ei);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (rd_count !== 40'd0 || irq !== 1'b0 || wr_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: count=%h irq=%b ready=%b expected 0/0/1",
               rd_count, irq, wr_ready);
    end
    step(1, 0, 0, 0, 0, 0, 0, "R1 enable off after reset");
    step(1, 1, 1, 0, 0, 0, 0, "R3 event in enable-write cycle");
    // R2 runs with a gap
    step(1, 0, 0, 0, 0, 0, 0, "R2 first event");
    step(1, 0, 0, 0, 0, 0, 0, "R2 second event");
    step(0, 0, 0, 0, 0, 0, 0, "R2 idle gap");
    step(1, 0, 0, 0, 0, 0, 0, "R2 third event");
    // R3 gating
    step(0, 1, 0, 0, 0, 0, 0, "R3 disable");
    step(1, 0, 0, 0, 0, 0, 0, "R3 event while disabled");
    step(1, 1, 1, 0, 0, 0, 0, "R3 re-enable cycle");
    // R4 / R6 sign extension
    step(0, 0, 0, 1, 32'h1234_5678, 0, 0, "R4 write bit31 low");
    step(0, 0, 0, 1, 32'h8000_0001, 0, 0, "R6 write bit31 high full width");
    // R5
    step(1, 0, 0, 1, 32'h0000_00A0, 0, 0, "R5 write beats event");
    // R10 / R7 preload minus five
    step(0, 0, 0, 1, 32'hFFFF_FFFB, 0, 0, "R10 preload");
    for (int k = 1; k <= 5; k++)
      step(1, 0, 0, 0, 0, 0, 0, (k == 5) ? "R7 wrap on fifth event" : "R10 before wrap");
    // R8 sticky, then clear
    step(1, 0, 0, 0, 0, 0, 0, "R8 flag held");
    step(0, 0, 0, 0, 0, 1, 0, "R8 clear");
    // R8 clear and wrap together
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R8 load all ones");
    step(1, 0, 0, 0, 0, 1, 0, "R8 wrap beats clear");
    step(0, 0, 0, 0, 0, 1, 0, "R8 clear after");
    // R9 narrow mode level
    step(0, 0, 0, 1, 32'h7FFF_FFFF, 0, 1, "R9 bit31 clear");
    step(1, 0, 0, 0, 0, 0, 1, "R9 bit31 set by event");
    step(0, 0, 0, 0, 0, 0, 1, "R9 level held");
    step(0, 0, 0, 1, 32'h0000_0000, 0, 1, "R9 level drops");
    step(0, 0, 0, 0, 0, 0, 0, "R9 back to wide");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule